// File: doc/BRIEF.md
# Boot-Phase Debug Access Gate

This block decides when the external debug port and the on-chip debug logic may act on the processor. It follows the life of the chip from power-on through boot-ROM execution and any later soft resets. After power-on both permissions are withheld. The boot ROM grants them when it signals that it has finished, provided the image it loaded is not secure. A soft reset then withdraws them according to one of three policies. The policy is picked by a select input that is captured at power-on.

The block also sits between the breakpoint and vector-catch comparators and the processor's halt logic. While the boot ROM is running, a hit whose fetch address lies in the boot-ROM window below 0x40000 is dropped. The comparators keep their settings across a soft reset, so the same hits pass again once the boot ROM has exited. Those hits then apply to the loader or user code that follows.

Top module: `dbg_boot_gate`

## Requirements
- R1: While the power-on reset `rst_n` is low, and in the first cycle after it is released, `dbg_port_en` and `dbg_sys_en` are both 0.
- R2: A `rom_done` pulse with `secure_img` = 0, taken while the boot ROM is running, sets both enables to 1 on the next clock edge.
- R3: A `rom_done` pulse with `secure_img` = 1 leaves both enables at 0. They stay at 0 through later soft resets and later `rom_done` pulses until the next power-on reset.
- R4: With policy code 2'b00 captured, a `soft_rst` pulse leaves both enables unchanged.
- R5: With policy code 2'b01 captured, a `soft_rst` pulse clears `dbg_port_en` on the next edge and leaves `dbg_sys_en` unchanged.
- R6: With policy code 2'b10 or 2'b11 captured, a `soft_rst` pulse clears both enables on the next edge. They stay at 0 until a non-secure `rom_done` sets them again.
- R7: From any reset until `rom_done` is taken, hits with `fetch_addr` below 0x40000 give no halt. Hits at 0x40000 or above still give a halt when `dbg_sys_en` is 1.
- R8: No halt output is ever 1 while `dbg_sys_en` is 0.
- R9: Once the boot ROM has exited, each raw hit present at any address gives a halt in the same cycle. Bit i of `bp_hit` maps to bit i of `bp_halt`, and `vc_hit` maps to `vc_halt`. Hits held unchanged across a soft reset therefore act again after the next exit.
- R10: A `rom_done` pulse arriving when the boot ROM is not running is ignored. Even with `secure_img` = 1 it leaves the enables unchanged.
- R11: `policy_sel` is sampled only during power-on reset. Changing it later does not alter the response to a soft reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| soft_rst | input | 1 | One-cycle soft-reset pulse |
| rom_done | input | 1 | One-cycle boot-ROM exit strobe |
| secure_img | input | 1 | Loaded image is secure, valid with `rom_done` |
| policy_sel | input | 2 | Soft-reset policy: 00 keep both, 01 port off, 1x both off |
| fetch_addr | input | ADDR_W | Current processor fetch address |
| bp_hit | input | NUM_BP | Raw breakpoint hits |
| vc_hit | input | 1 | Raw vector-catch hit |
| dbg_port_en | output | 1 | External debug port may act |
| dbg_sys_en | output | 1 | On-chip debug logic may act |
| bp_halt | output | NUM_BP | Gated breakpoint halt requests |
| vc_halt | output | 1 | Gated vector-catch halt request |

## Verification
The bench builds the block with ADDR_W = 20, NUM_BP = 4 and ROM_TOP = 0x40000. The 20-bit address width puts both edges of the window within easy reach of the stimulus: 0x3FFFF just inside it and 0x40000 just outside. Four breakpoint lanes plus the vector-catch lane let distinct hit patterns show that each lane is gated separately. Every policy code, including the alias 2'b11, is captured through its own power-on reset, so each soft-reset policy and the secure lock can be checked in turn.

// File: rtl/dbg_gate_pkg.sv
// Package: shared policy encoding for the boot-phase debug gate.
// Assumes: two-bit policy select; codes 2'b10 and 2'b11 both withdraw everything.
package dbg_gate_pkg;
    typedef enum logic [1:0] {
        POL_KEEP_ALL  = 2'b00,
        POL_PORT_OFF  = 2'b01,
        POL_ALL_OFF   = 2'b10,
        POL_ALL_OFF_X = 2'b11
    } policy_t;
endpackage

// File: rtl/dbg_enable_ctrl.sv
// Module: enable state of the debug port and debug system.
// Captures the soft-reset policy at power-on. Tracks whether the boot ROM is
// running and whether a secure image has locked debug out. Drives both
// enables as registers.
// Assumes: soft_rst and rom_done are single-cycle pulses; soft_rst wins when
// both arrive together.
module dbg_enable_ctrl
    import dbg_gate_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    soft_rst,
    input  logic    rom_done,
    input  logic    secure_img,
    input  logic [1:0] policy_sel,
    output policy_t mode_q,
    output logic    boot_busy,
    output logic    port_en,
    output logic    sys_en
);
    logic lock_q;
    logic keep_port;
    logic keep_sys;

    // Purpose: decode which enables survive a soft reset under the captured policy.
    always_comb begin
        keep_port = (mode_q == POL_KEEP_ALL);
        keep_sys  = (mode_q == POL_KEEP_ALL) || (mode_q == POL_PORT_OFF);
    end

    // Purpose: advance the enable, lock and boot-running state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= policy_t'(policy_sel);
            boot_busy <= 1'b1;
            lock_q    <= 1'b0;
            port_en   <= 1'b0;
            sys_en    <= 1'b0;
        end else if (soft_rst) begin
            boot_busy <= 1'b1;
            port_en   <= port_en & keep_port;
            sys_en    <= sys_en & keep_sys;
        end else if (rom_done && boot_busy) begin
            boot_busy <= 1'b0;
            if (secure_img || lock_q) begin
                lock_q  <= 1'b1;
                port_en <= 1'b0;
                sys_en  <= 1'b0;
            end else begin
                port_en <= 1'b1;
                sys_en  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dbg_hit_gate.sv
// Module: gates raw breakpoint and vector-catch hits into halt requests.
// A hit passes when the debug system is enabled, unless the boot ROM is
// running and the fetch address lies below ROM_TOP.
// Assumes: hits and fetch address are valid in the same cycle; the window
// starts at address zero.
module dbg_hit_gate #(
    parameter int          ADDR_W  = 32,
    parameter int          LANES   = 5,
    parameter logic [63:0] ROM_TOP = 64'h4_0000
) (
    input  logic              sys_en,
    input  logic              boot_busy,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [LANES-1:0]  hit,
    output logic [LANES-1:0]  halt
);
    localparam logic [ADDR_W-1:0] TOP_A = ROM_TOP[ADDR_W-1:0];

    logic in_window;
    logic pass;

    // Purpose: decide whether hits may reach the halt logic this cycle.
    always_comb begin
        in_window = (fetch_addr < TOP_A);
        pass      = sys_en && !(boot_busy && in_window);
    end

    // One identical gate per hit lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign halt[g] = hit[g] & pass;
    end
endmodule

// File: rtl/dbg_boot_gate.sv
// Module: top of the boot-phase debug access gate.
// Joins the enable controller with the hit gate. Breakpoint lanes come first
// and the vector-catch lane is the top lane of the gate.
// Assumes: ROM_TOP fits in ADDR_W bits.
module dbg_boot_gate #(
    parameter int          ADDR_W  = 32,
    parameter int          NUM_BP  = 4,
    parameter logic [63:0] ROM_TOP = 64'h4_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              rom_done,
    input  logic              secure_img,
    input  logic [1:0]        policy_sel,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [NUM_BP-1:0] bp_hit,
    input  logic              vc_hit,
    output logic              dbg_port_en,
    output logic              dbg_sys_en,
    output logic [NUM_BP-1:0] bp_halt,
    output logic              vc_halt
);
    import dbg_gate_pkg::*;

    localparam int LANES = NUM_BP + 1;

    policy_t          mode_q;
    logic             boot_busy;
    logic [LANES-1:0] lane_hit;
    logic [LANES-1:0] lane_halt;

    dbg_enable_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .rom_done   (rom_done),
        .secure_img (secure_img),
        .policy_sel (policy_sel),
        .mode_q     (mode_q),
        .boot_busy  (boot_busy),
        .port_en    (dbg_port_en),
        .sys_en     (dbg_sys_en)
    );

    // Purpose: pack the breakpoint and vector-catch hits into gate lanes.
    always_comb lane_hit = {vc_hit, bp_hit};

    dbg_hit_gate #(
        .ADDR_W  (ADDR_W),
        .LANES   (LANES),
        .ROM_TOP (ROM_TOP)
    ) u_gate (
        .sys_en     (dbg_sys_en),
        .boot_busy  (boot_busy),
        .fetch_addr (fetch_addr),
        .hit        (lane_hit),
        .halt       (lane_halt)
    );

    // Purpose: unpack the gated lanes onto the halt outputs.
    always_comb begin
        bp_halt = lane_halt[NUM_BP-1:0];
        vc_halt = lane_halt[NUM_BP];
    end
endmodule

// File: rtl/dbg_boot_gate_chk.sv
// Module: property checker for dbg_boot_gate, attached with bind.
// Observes ports plus the captured policy and the boot-running flag.
module dbg_boot_gate_chk #(
    parameter int          ADDR_W  = 32,
    parameter int          NUM_BP  = 4,
    parameter logic [63:0] ROM_TOP = 64'h4_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic              rom_done,
    input logic              secure_img,
    input logic [1:0]        mode_q,
    input logic              boot_busy,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              dbg_port_en,
    input logic              dbg_sys_en,
    input logic [NUM_BP-1:0] bp_halt,
    input logic              vc_halt
);
    localparam logic [ADDR_W-1:0] TOP_A = ROM_TOP[ADDR_W-1:0];

    // R1: enables are clear in the first cycle out of power-on reset.
    a_r1_por_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!dbg_port_en && !dbg_sys_en));

    // R2: the debug system only rises after a non-secure boot-ROM exit.
    a_r2_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dbg_sys_en) |-> ($past(rom_done) && !$past(secure_img)));

    // R4: keep-all policy leaves both enables unchanged over a soft reset.
    a_r4_keep_all: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && mode_q == 2'b00) |=> ($stable(dbg_port_en) && $stable(dbg_sys_en)));

    // R5: port-off policy drops the port and holds the system.
    a_r5_port_off: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && mode_q == 2'b01) |=> (!dbg_port_en && $stable(dbg_sys_en)));

    // R6: production policy drops both enables.
    a_r6_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && mode_q[1]) |=> (!dbg_port_en && !dbg_sys_en));

    // R7: no halt inside the window while the boot ROM runs.
    a_r7_window_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_busy && fetch_addr < TOP_A) |-> (bp_halt == '0 && !vc_halt));

    // R8: no halt while the debug system is disabled.
    a_r8_sys_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_sys_en |-> (bp_halt == '0 && !vc_halt));
endmodule

bind dbg_boot_gate dbg_boot_gate_chk #(
    .ADDR_W  (ADDR_W),
    .NUM_BP  (NUM_BP),
    .ROM_TOP (ROM_TOP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .rom_done    (rom_done),
    .secure_img  (secure_img),
    .mode_q      (mode_q),
    .boot_busy   (boot_busy),
    .fetch_addr  (fetch_addr),
    .dbg_port_en (dbg_port_en),
    .dbg_sys_en  (dbg_sys_en),
    .bp_halt     (bp_halt),
    .vc_halt     (vc_halt)
);

// File: tb/tb_dbg_boot_gate.sv
// Scoreboard bench: the driver task applies one cycle of stimulus and pushes
// the expected outputs, computed from the requirements, into a queue. The
// monitor pops one entry after every rising edge and compares.
module tb_dbg_boot_gate;
    localparam int AW = 20;
    localparam int NB = 4;

    typedef struct {
        logic          port;
        logic          sys;
        logic [NB-1:0] bp;
        logic          vc;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          soft_rst = 1'b0;
    logic          rom_done = 1'b0;
    logic          secure_img = 1'b0;
    logic [1:0]    policy_sel = 2'b00;
    logic [AW-1:0] fetch_addr = '0;
    logic [NB-1:0] bp_hit = '0;
    logic          vc_hit = 1'b0;
    logic          dbg_port_en, dbg_sys_en, vc_halt;
    logic [NB-1:0] bp_halt;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 0;

    // Reference state, written only by the driver from the requirements.
    logic       m_port, m_sys, m_busy, m_lock;
    logic [1:0] m_mode;

    always #2.5 clk = ~clk;

    dbg_boot_gate #(.ADDR_W(AW), .NUM_BP(NB), .ROM_TOP(64'h4_0000)) dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rom_done(rom_done),
        .secure_img(secure_img), .policy_sel(policy_sel), .fetch_addr(fetch_addr),
        .bp_hit(bp_hit), .vc_hit(vc_hit), .dbg_port_en(dbg_port_en),
        .dbg_sys_en(dbg_sys_en), .bp_halt(bp_halt), .vc_halt(vc_halt)
    );

    // One cycle of stimulus plus the expected outputs after the next edge.
    task automatic cyc(input logic rn, input logic sr, input logic dn, input logic sec,
                       input logic [1:0] sel, input logic [AW-1:0] a,
                       input logic [NB-1:0] bp, input logic vc, input string tag);
        exp_t e;
        logic pass;
        @(negedge clk);
        rst_n = rn; soft_rst = sr; rom_done = dn; secure_img = sec;
        policy_sel = sel; fetch_addr = a; bp_hit = bp; vc_hit = vc;
        if (!rn) begin
            m_mode = sel; m_busy = 1'b1; m_lock = 1'b0; m_port = 1'b0; m_sys = 1'b0;
        end else if (sr) begin
            m_busy = 1'b1;
            if (m_mode == 2'b01) m_port = 1'b0;
            else if (m_mode[1]) begin m_port = 1'b0; m_sys = 1'b0; end
        end else if (dn && m_busy) begin
            m_busy = 1'b0;
            if (sec || m_lock) begin m_lock = 1'b1; m_port = 1'b0; m_sys = 1'b0; end
            else begin m_port = 1'b1; m_sys = 1'b1; end
        end
        pass = m_sys && !(m_busy && a < 20'h40000);
        e.port = m_port; e.sys = m_sys;
        e.bp = pass ? bp : '0; e.vc = pass & vc; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare one expected entry after each rising edge.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (dbg_port_en !== e.port || dbg_sys_en !== e.sys ||
                bp_halt !== e.bp || vc_halt !== e.vc) begin
                n_bad++;
                $display("FAIL %s: got port=%b sys=%b bp=%b vc=%b, expected port=%b sys=%b bp=%b vc=%b",
                         e.tag, dbg_port_en, dbg_sys_en, bp_halt, vc_halt,
                         e.port, e.sys, e.bp, e.vc);
            end
        end
    end

    initial begin
        // R1 / R8: power-on reset under policy 00, hits present.
        cyc(0,0,0,0,2'b00,20'h00100,4'hF,1,"R1");
        cyc(0,0,0,0,2'b00,20'h50000,4'hF,1,"R1");
        cyc(1,0,0,0,2'b00,20'h50000,4'hF,1,"R8");
        cyc(1,0,0,0,2'b00,20'h00100,4'h3,1,"R8");
        // R2: non-secure exit.
        cyc(1,0,1,0,2'b00,20'h00100,4'h0,0,"R2");
        // R9: hits pass anywhere after exit.
        cyc(1,0,0,0,2'b00,20'h00100,4'h5,1,"R9");
        cyc(1,0,0,0,2'b00,20'h3FFFF,4'hA,0,"R9");
        // R10: strobe with secure flag while boot ROM idle is ignored.
        cyc(1,0,1,1,2'b00,20'h00010,4'h1,0,"R10");
        cyc(1,0,0,0,2'b00,20'h00010,4'h2,1,"R10");
        // R11 / R4: select changed after power-on; soft reset keeps both.
        cyc(1,1,0,0,2'b11,20'h3FFFF,4'h6,1,"R11");
        cyc(1,0,0,0,2'b11,20'h3FFFF,4'h6,1,"R7");
        cyc(1,0,0,0,2'b11,20'h40000,4'h6,1,"R7");
        cyc(1,0,1,0,2'b11,20'h00000,4'h6,1,"R4");
        cyc(1,0,0,0,2'b11,20'h3FFFF,4'h6,1,"R9");
        // R5: port-off policy.
        cyc(0,0,0,0,2'b01,20'h0,4'h0,0,"R1");
        cyc(1,0,1,0,2'b01,20'h0,4'h0,0,"R2");
        cyc(1,1,0,0,2'b01,20'h40000,4'h9,1,"R5");
        cyc(1,0,0,0,2'b01,20'h00010,4'h9,1,"R5");
        cyc(1,0,1,0,2'b01,20'h00010,4'h9,1,"R5");
        cyc(1,0,0,0,2'b01,20'h00010,4'h9,1,"R9");
        // R6: production policy, code 10.
        cyc(0,0,0,0,2'b10,20'h0,4'h0,0,"R1");
        cyc(1,0,1,0,2'b10,20'h0,4'h0,0,"R2");
        cyc(1,1,0,0,2'b10,20'h40000,4'hF,1,"R6");
        cyc(1,0,0,0,2'b10,20'h80000,4'hF,1,"R6");
        cyc(1,0,1,0,2'b10,20'h00000,4'hC,1,"R6");
        cyc(1,0,0,0,2'b10,20'h00000,4'hC,1,"R9");
        // R6: production policy alias code 11.
        cyc(0,0,0,0,2'b11,20'h0,4'h0,0,"R1");
        cyc(1,0,1,0,2'b11,20'h0,4'h0,0,"R2");
        cyc(1,1,0,0,2'b11,20'h40000,4'h3,0,"R6");
        cyc(1,0,0,0,2'b11,20'h40000,4'h3,0,"R6");
        // R3: secure exit locks debug out until power-on.
        cyc(0,0,0,0,2'b00,20'h0,4'h0,0,"R1");
        cyc(1,0,1,1,2'b00,20'h50000,4'hF,1,"R3");
        cyc(1,1,0,0,2'b00,20'h50000,4'hF,1,"R3");
        cyc(1,0,1,0,2'b00,20'h50000,4'hF,1,"R3");
        cyc(1,0,0,0,2'b00,20'h50000,4'hF,1,"R3");
        cyc(0,0,0,0,2'b00,20'h0,4'h0,0,"R1");
        cyc(1,0,1,0,2'b00,20'h50000,4'h4,1,"R3");
        cyc(1,0,0,0,2'b00,20'h50000,4'h4,1,"R3");
        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule